// File: doc/BRIEF.md
# Serial Bus Collision Detection Unit

This unit sits beside a serial transmitter and compares every transmitted bit with the level that comes back on the shared receive line. When the transmitter releases the line (sends 1) but the line reads 0 at the sampling point, another driver owns the bus. The unit then raises a sticky arbitration-lost flag and a one-cycle interrupt pulse. It can also pulse a request that clears the transmitter's enable bit. The sampling point comes either from the rising edge of the transfer clock or from an external timer underflow strobe. The flag is written either after every sampled bit or once at the end of each byte.

The unit can also gate the start of a transfer. In the ordinary case a pending transfer is permitted on the next cycle. In the edge-start case the permit waits until the receive line falls. When two-wire bus mode is on, the unit also watches a data line and a clock line for START and STOP conditions and keeps a bus-busy flag from them. The receive line, the data line and the clock line are asynchronous and pass through a two-flop synchronizer.

Top module: `bus_collision_unit`

## Requirements
- R1: After reset, al_flag, bus_busy, coll_irq, te_clear and tx_start_ok are all 0.
- R2: A bit is a collision only when tx_bit is 1 and the synchronized rx_line is 0 at a sampling point. The other three combinations produce no collision.
- R3: With cfg_sample_timer = 0, sampling points are the clock cycles in which xfer_clk rises. With cfg_sample_timer = 1, sampling points are the cycles in which timer_uf is 1. The source that is not selected has no effect.
- R4: In per-bit mode (cfg_per_byte = 0), a colliding sample sets al_flag and gives coll_irq = 1 for exactly one cycle. Both appear in the cycle after the sample.
- R5: In per-byte mode (cfg_per_byte = 1), collisions are ORed over BYTE_BITS (default 8) consecutive samples of an active transfer. al_flag and coll_irq are written only at the last sample of the byte. A byte with no collision gives no pulse.
- R6: al_flag stays 1 until al_clr is 1 in a cycle. If a flag-setting collision falls in the same cycle as al_clr, the flag stays set.
- R7: With cfg_auto_clear = 1, te_clear pulses in the same cycle as coll_irq. With cfg_auto_clear = 0, te_clear stays 0.
- R8: With cfg_start_on_edge = 0, tx_start_ok becomes 1 one cycle after tx_pending is 1. With cfg_start_on_edge = 1, tx_start_ok waits for a falling edge of the synchronized rx_line. tx_start_ok drops one cycle after tx_pending drops. Samples taken while tx_start_ok is 0 are ignored, and dropping tx_start_ok restarts the byte count.
- R9: With cfg_i2c_mode = 1, a synchronized sda_in falling edge while scl_in is high sets bus_busy. A rising edge while scl_in is high clears it. Edges while scl_in is low change nothing.
- R10: With cfg_i2c_mode = 0, bus_busy is 0, START conditions are ignored, and leaving two-wire mode clears a set bus_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i2c_mode | input | 1 | 1 enables START/STOP tracking |
| cfg_sample_timer | input | 1 | 0: sample on xfer_clk rise, 1: sample on timer_uf |
| cfg_per_byte | input | 1 | 0: flag written per bit, 1: once per byte |
| cfg_start_on_edge | input | 1 | 1: transfer waits for falling rx_line |
| cfg_auto_clear | input | 1 | 1: collision requests transmit-enable clear |
| tx_pending | input | 1 | Transmitter wants to (or does) send |
| tx_bit | input | 1 | Bit currently driven on the line |
| rx_line | input | 1 | Received line level, asynchronous |
| xfer_clk | input | 1 | Transfer clock level, synchronous to clk |
| timer_uf | input | 1 | Timer underflow strobe, one cycle |
| sda_in | input | 1 | Two-wire data line, asynchronous |
| scl_in | input | 1 | Two-wire clock line, asynchronous |
| al_clr | input | 1 | Software write of 0 to the arbitration-lost flag |
| al_flag | output | 1 | Sticky arbitration-lost flag |
| bus_busy | output | 1 | Bus busy between START and STOP |
| coll_irq | output | 1 | One-cycle collision interrupt |
| te_clear | output | 1 | One-cycle request to clear transmit enable |
| tx_start_ok | output | 1 | Transfer permitted |

## Verification
Two events can fall in the same cycle: a software clear of the arbitration-lost flag and a collision sample that sets it. The bench drives al_clr high in the very cycle in which a timer strobe samples a released bit against a low line. It then expects the flag to read 1 with an interrupt pulse, because setting must win over clearing. The bench also drives a START condition and then leaves two-wire mode, and checks that bus_busy is cleared and not held over.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  // Released line (1) observed low (0) means another driver won.
  function automatic logic collision_of(input logic tx, input logic rx);
    return tx & ~rx;
  endfunction

  // Data falls while clock is high.
  function automatic logic start_cond(input logic sda_prev, input logic sda_now,
                                      input logic scl_now);
    return sda_prev & ~sda_now & scl_now;
  endfunction

  // Data rises while clock is high.
  function automatic logic stop_cond(input logic sda_prev, input logic sda_now,
                                     input logic scl_now);
    return ~sda_prev & sda_now & scl_now;
  endfunction

endpackage

// File: rtl/bcu_sync.sv
module bcu_sync #(
  parameter int WIDTH   = 3,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/bcu_tx_gate.sv
module bcu_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_pending,
  input  logic start_on_edge,
  input  logic rx_s,
  output logic tx_start_ok
);

  logic rx_p;
  logic rx_fall;

  assign rx_fall = rx_p & ~rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_p        <= 1'b1;
      tx_start_ok <= 1'b0;
    end else begin
      rx_p        <= rx_s;
      tx_start_ok <= tx_pending & (tx_start_ok | ~start_on_edge | rx_fall);
    end
  end

  // R8: in edge-start mode the permit only rises after a falling receive line
  assert_edge_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_start_ok) && $past(start_on_edge)) |-> $past(rx_fall));

  // R8: permit withdrawn once the request is gone
  assert_permit_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pending |=> !tx_start_ok);

endmodule

// File: rtl/bcu_busy.sv
module bcu_busy
  import bcu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic i2c_mode,
  input  logic sda_s,
  input  logic scl_s,
  output logic bus_busy
);

  logic sda_p;
  logic start_seen;
  logic stop_seen;

  assign start_seen = start_cond(sda_p, sda_s, scl_s);
  assign stop_seen  = stop_cond(sda_p, sda_s, scl_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_p    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      sda_p <= sda_s;
      if (!i2c_mode)       bus_busy <= 1'b0;
      else if (start_seen) bus_busy <= 1'b1;
      else if (stop_seen)  bus_busy <= 1'b0;
    end
  end

  // R10: no busy indication outside two-wire mode
  assert_free_outside_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !i2c_mode |=> !bus_busy);

  // R9: START always leads to busy
  assert_start_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_mode && start_seen) |=> bus_busy);

  // R9: STOP always leads to free
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !bus_busy);

endmodule

// File: rtl/bcu_arb.sv
module bcu_arb
  import bcu_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic active,
  input  logic per_byte,
  input  logic auto_clear,
  input  logic tx_bit,
  input  logic rx_s,
  input  logic al_clr,
  output logic al_flag,
  output logic coll_irq,
  output logic te_clear
);

  localparam int CNT_W = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             acc;
  logic             mismatch;
  logic             take;
  logic             byte_end;
  logic             set_event;

  assign mismatch  = collision_of(tx_bit, rx_s);
  assign take      = sample & active;
  assign byte_end  = take & (bit_cnt == LAST);
  assign set_event = per_byte ? (byte_end & (acc | mismatch)) : (take & mismatch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      acc     <= 1'b0;
    end else if (!active) begin
      bit_cnt <= '0;
      acc     <= 1'b0;
    end else if (take) begin
      if (byte_end) begin
        bit_cnt <= '0;
        acc     <= 1'b0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        acc     <= acc | mismatch;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_flag  <= 1'b0;
      coll_irq <= 1'b0;
      te_clear <= 1'b0;
    end else begin
      if (set_event)   al_flag <= 1'b1;
      else if (al_clr) al_flag <= 1'b0;
      coll_irq <= set_event;
      te_clear <= set_event & auto_clear;
    end
  end

  // R6: the flag only rises together with an interrupt
  assert_flag_by_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al_flag) |-> coll_irq);

  // R6: a clear without a competing collision empties the flag
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (al_clr && !set_event) |=> !al_flag);

  // R7: enable-clear request requires the auto-clear option
  assert_te_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    te_clear |-> $past(auto_clear));

  // R8: idle transfers never interrupt
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !coll_irq);

  // R5: per-byte interrupts only at a byte boundary
  assert_byte_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_irq && $past(per_byte)) |-> ($past(bit_cnt) == LAST));

endmodule

// File: rtl/bus_collision_unit.sv
module bus_collision_unit #(
  parameter int BYTE_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_i2c_mode,
  input  logic cfg_sample_timer,
  input  logic cfg_per_byte,
  input  logic cfg_start_on_edge,
  input  logic cfg_auto_clear,
  input  logic tx_pending,
  input  logic tx_bit,
  input  logic rx_line,
  input  logic xfer_clk,
  input  logic timer_uf,
  input  logic sda_in,
  input  logic scl_in,
  input  logic al_clr,
  output logic al_flag,
  output logic bus_busy,
  output logic coll_irq,
  output logic te_clear,
  output logic tx_start_ok
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_lines;
  logic [NSYNC-1:0] sync_lines;
  logic             rx_s;
  logic             sda_s;
  logic             scl_s;
  logic             xclk_p;
  logic             xclk_rise;
  logic             sample_pt;

  assign raw_lines = {scl_in, sda_in, rx_line};
  assign rx_s      = sync_lines[0];
  assign sda_s     = sync_lines[1];
  assign scl_s     = sync_lines[2];

  bcu_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_lines),
    .q_sync  (sync_lines)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xclk_p <= 1'b0;
    else        xclk_p <= xfer_clk;
  end

  assign xclk_rise = xfer_clk & ~xclk_p;
  assign sample_pt = cfg_sample_timer ? timer_uf : xclk_rise;

  bcu_tx_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_pending    (tx_pending),
    .start_on_edge (cfg_start_on_edge),
    .rx_s          (rx_s),
    .tx_start_ok   (tx_start_ok)
  );

  bcu_arb #(.BYTE_BITS(BYTE_BITS)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (sample_pt),
    .active     (tx_start_ok),
    .per_byte   (cfg_per_byte),
    .auto_clear (cfg_auto_clear),
    .tx_bit     (tx_bit),
    .rx_s       (rx_s),
    .al_clr     (al_clr),
    .al_flag    (al_flag),
    .coll_irq   (coll_irq),
    .te_clear   (te_clear)
  );

  bcu_busy u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .i2c_mode (cfg_i2c_mode),
    .sda_s    (sda_s),
    .scl_s    (scl_s),
    .bus_busy (bus_busy)
  );

  // R3: with the timer source chosen, no interrupt without a strobe
  assert_timer_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sample_timer && !timer_uf) |=> !coll_irq);

  // R4: the interrupt is accompanied by the flag
  assert_irq_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coll_irq |-> al_flag);

endmodule

// File: tb/tb_bus_collision_unit.sv
module tb_bus_collision_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_i2c_mode = 0, cfg_sample_timer = 0, cfg_per_byte = 0;
  logic cfg_start_on_edge = 0, cfg_auto_clear = 0;
  logic tx_pending = 0, tx_bit = 0, rx_line = 1, xfer_clk = 0, timer_uf = 0;
  logic sda_in = 1, scl_in = 1, al_clr = 0;
  logic al_flag, bus_busy, coll_irq, te_clear, tx_start_ok;

  always #4 clk = ~clk;

  bus_collision_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_i2c_mode(cfg_i2c_mode), .cfg_sample_timer(cfg_sample_timer),
    .cfg_per_byte(cfg_per_byte), .cfg_start_on_edge(cfg_start_on_edge),
    .cfg_auto_clear(cfg_auto_clear), .tx_pending(tx_pending), .tx_bit(tx_bit),
    .rx_line(rx_line), .xfer_clk(xfer_clk), .timer_uf(timer_uf),
    .sda_in(sda_in), .scl_in(scl_in), .al_clr(al_clr),
    .al_flag(al_flag), .bus_busy(bus_busy), .coll_irq(coll_irq),
    .te_clear(te_clear), .tx_start_ok(tx_start_ok)
  );

  typedef struct {
    string tag;
    int    sel;   // 0 al_flag, 1 bus_busy, 2 coll_irq, 3 te_clear, 4 tx_start_ok
    logic  val;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Monitor: compares queued expectations two time units after the driver pushes them.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic act;
        e = exp_q.pop_front();
        case (e.sel)
          0: act = al_flag;
          1: act = bus_busy;
          2: act = coll_irq;
          3: act = te_clear;
          default: act = tx_start_ok;
        endcase
        n_cmp++;
        if (act !== e.val) begin
          n_bad++;
          $display("FAIL %s: sel %0d actual %b expected %b", e.tag, e.sel, act, e.val);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic expect_o(input string tag, input int sel, input logic val);
    exp_t e;
    e.tag = tag; e.sel = sel; e.val = val;
    exp_q.push_back(e);
  endtask

  task automatic strobe_timer();
    timer_uf = 1; step(); timer_uf = 0;
  endtask

  task automatic rise_xclk();
    xfer_clk = 1; step(); xfer_clk = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    steps(2);
    rst_n = 1;
    #1;
    expect_o("R1 al", 0, 0); expect_o("R1 busy", 1, 0); expect_o("R1 irq", 2, 0);
    expect_o("R1 te", 3, 0); expect_o("R1 ok", 4, 0);
    step();

    // R8 ordinary start
    tx_pending = 1; step(); expect_o("R8 ordinary start", 4, 1);

    // R3 / R4 / R2 per-bit on transfer clock
    tx_bit = 1; rx_line = 0; steps(3);
    strobe_timer(); expect_o("R3 timer ignored irq", 2, 0); expect_o("R3 timer ignored al", 0, 0);
    rise_xclk(); expect_o("R4 irq", 2, 1); expect_o("R4 al", 0, 1); expect_o("R7 te off", 3, 0);
    step(); expect_o("R4 one-cycle irq", 2, 0); expect_o("R6 sticky", 0, 1);
    al_clr = 1; step(); al_clr = 0; expect_o("R6 cleared", 0, 0);

    // R2 non-colliding combinations
    tx_bit = 0; rise_xclk(); expect_o("R2 tx0 rx0", 2, 0);
    rx_line = 1; steps(3); rise_xclk(); expect_o("R2 tx0 rx1", 2, 0);
    tx_bit = 1; rise_xclk(); expect_o("R2 tx1 rx1", 2, 0); expect_o("R2 flag stays 0", 0, 0);
    rx_line = 0; steps(3);

    // R3 timer source, R7 auto clear
    cfg_sample_timer = 1; cfg_auto_clear = 1; step();
    rise_xclk(); expect_o("R3 xclk ignored", 2, 0);
    strobe_timer(); expect_o("R3 timer irq", 2, 1); expect_o("R7 te pulse", 3, 1);
    step(); expect_o("R7 te one-cycle", 3, 0);
    al_clr = 1; step(); al_clr = 0; expect_o("R6 cleared again", 0, 0);

    // R6 set wins over simultaneous clear
    al_clr = 1; timer_uf = 1; step(); al_clr = 0; timer_uf = 0;
    expect_o("R6 set beats clear", 0, 1); expect_o("R6 irq on tie", 2, 1);
    step();

    // R5 per-byte
    tx_pending = 0; steps(2);
    al_clr = 1; step(); al_clr = 0;
    cfg_per_byte = 1; cfg_auto_clear = 0;
    tx_pending = 1; step(); expect_o("R8 restart", 4, 1);
    for (int i = 0; i < 8; i++) begin
      tx_bit = (i == 2);
      strobe_timer();
      expect_o($sformatf("R5 byte1 bit%0d irq", i), 2, i == 7);
      expect_o($sformatf("R5 byte1 bit%0d al", i), 0, i == 7);
      step();
    end
    al_clr = 1; step(); al_clr = 0;
    tx_bit = 0;
    for (int i = 0; i < 8; i++) begin
      strobe_timer();
      expect_o($sformatf("R5 clean byte bit%0d", i), 2, 0);
      step();
    end
    expect_o("R5 clean byte al", 0, 0);

    // R8 samples ignored while not permitted
    cfg_per_byte = 0; tx_pending = 0; steps(2);
    expect_o("R8 permit dropped", 4, 0);
    tx_bit = 1; strobe_timer(); expect_o("R8 inactive irq", 2, 0); expect_o("R8 inactive al", 0, 0);

    // R8 edge start
    rx_line = 1; steps(3);
    cfg_start_on_edge = 1; tx_pending = 1; step(); expect_o("R8 wait edge a", 4, 0);
    step(); expect_o("R8 wait edge b", 4, 0);
    rx_line = 0; step(); expect_o("R8 edge sync 1", 4, 0);
    step(); expect_o("R8 edge sync 2", 4, 0);
    step(); expect_o("R8 edge start", 4, 1);
    tx_pending = 0; step(); expect_o("R8 edge drop", 4, 0);
    cfg_start_on_edge = 0;

    // R10 / R9 bus busy
    sda_in = 0; steps(4); expect_o("R10 START ignored", 1, 0);
    sda_in = 1; steps(4);
    cfg_i2c_mode = 1; step();
    sda_in = 0; steps(4); expect_o("R9 START sets", 1, 1);
    sda_in = 1; steps(4); expect_o("R9 STOP clears", 1, 0);
    scl_in = 0; steps(4); sda_in = 0; steps(4); expect_o("R9 scl low fall", 1, 0);
    sda_in = 1; steps(4); scl_in = 1; steps(4);
    sda_in = 0; steps(4); expect_o("R9 START again", 1, 1);
    cfg_i2c_mode = 0; step(); expect_o("R10 leave mode clears", 1, 0);
    steps(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule